// File: doc/BRIEF.md
# Channel Soft-Stop Ramp Sequencer

This block shuts one regulator channel down in an orderly way, working only on digital voltage codes. A single-cycle request from the host to turn the channel off starts the sequence. The block captures the present target code and a 16-bit configuration word. It waits a programmable hold-off in 250 µs units, then lowers its target output by 5 codes (50 mV at 10 mV per code) at a programmable number of microseconds per step. It stops when the code reaches the discharge threshold.

All timing comes from a one-cycle tick at 1 µs intervals. The hold-off unit is 250 of these ticks. A request to turn the channel back on cancels a sequence in progress and leaves the target where it stands. The block raises busy while a sequence runs and gives a one-cycle done pulse when the threshold is reached.

Top module: `soft_stop_seq`

## Requirements
- R1: After reset, busy and done are 0 and tgt_out is 0.
- R2: In idle, a cycle with off_req=1 and on_req=0 starts a sequence. From the next cycle busy is 1 and tgt_out equals the tgt_in value sampled on that cycle.
- R3: cfg_word bits [15:10] hold a hold-off count N. The hold-off phase consumes max(1, 250·N) ticks. Each step then consumes max(1, F) ticks, where F is cfg_word bits [9:0].
- R4: Each step lowers tgt_out by 5 codes, and the new value appears in the cycle after the tick that completes the step.
- R5: A step never takes tgt_out below thr_code. When tgt_out is less than 5 codes above the threshold, the step sets it equal to the threshold. When tgt_out is already at or below the threshold, the step leaves it unchanged.
- R6: The step that leaves tgt_out at or below thr_code ends the sequence. done is 1 for exactly one cycle, busy falls in that same cycle, and the block returns to idle.
- R7: on_req=1 while busy aborts the sequence in the next cycle. busy clears, no done pulse is given, and tgt_out keeps its value.
- R8: off_req while busy has no effect on the running sequence's timing or values.
- R9: A hold-off field of 0 ends the hold-off phase on the first tick. A fall-time field of 0 behaves as 1 tick per step.
- R10: cfg_word and tgt_in are captured at start. Changing them later has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every 1 µs |
| cfg_word | input | 16 | Hold-off [15:10], fall time per step [9:0] |
| off_req | input | 1 | Channel-off strobe from the host |
| on_req | input | 1 | Channel-on strobe, aborts a sequence |
| tgt_in | input | 10 | Present target code, 10 mV per code |
| thr_code | input | 10 | Discharge threshold code |
| tgt_out | output | 10 | Falling target code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the threshold is reached |

## Verification
The step-size assertion assumes that thr_code stays constant while a sequence is running, because the floor is compared against its present value. The stimulus changes the threshold only while the block is idle. It assumes nothing about tick spacing or about how strobes overlap with ticks. The bench therefore drives a free-running tick every third clock and places off and on strobes on arbitrary cycles, including cycles where both are high and cycles that coincide with a tick.

// File: rtl/soft_stop_seq.sv
module soft_stop_seq #(
  parameter int CODE_W     = 10,
  parameter int DLY_W      = 6,
  parameter int FALL_W     = 10,
  parameter int UNIT_TICKS = 250,
  parameter int STEP_CODES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic [15:0]       cfg_word,
  input  logic              off_req,
  input  logic              on_req,
  input  logic [CODE_W-1:0] tgt_in,
  input  logic [CODE_W-1:0] thr_code,
  output logic [CODE_W-1:0] tgt_out,
  output logic              busy,
  output logic              done
);
  localparam int DLY_MAX = ((1 << DLY_W) - 1) * UNIT_TICKS;
  localparam int FALL_MAX = (1 << FALL_W) - 1;
  localparam int CNT_W = $clog2((DLY_MAX > FALL_MAX ? DLY_MAX : FALL_MAX) + 2);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RAMP} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt, dly_lim, fall_lim, dly_raw, fall_raw;
  logic [CODE_W-1:0] step_val;
  logic start, cnt_hit;

  assign dly_raw  = CNT_W'(cfg_word[15:16-DLY_W]) * CNT_W'(UNIT_TICKS);
  assign fall_raw = CNT_W'(cfg_word[FALL_W-1:0]);
  assign start    = (st == S_IDLE) && off_req && !on_req;
  assign cnt_hit  = (cnt + 1'b1) >= ((st == S_WAIT) ? dly_lim : fall_lim);
  assign busy     = (st != S_IDLE);

  always_comb begin
    if (tgt_out <= thr_code)
      step_val = tgt_out;
    else if ((tgt_out - thr_code) > CODE_W'(STEP_CODES))
      step_val = tgt_out - CODE_W'(STEP_CODES);
    else
      step_val = thr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      dly_lim  <= '0;
      fall_lim <= '0;
      tgt_out  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st       <= S_WAIT;
        cnt      <= '0;
        tgt_out  <= tgt_in;
        dly_lim  <= (dly_raw == '0) ? CNT_W'(1) : dly_raw;
        fall_lim <= (fall_raw == '0) ? CNT_W'(1) : fall_raw;
      end else if (busy && on_req) begin
        st <= S_IDLE;
      end else if (busy && tick_us) begin
        if (!cnt_hit) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (st == S_WAIT) begin
            st <= S_RAMP;
          end else begin
            tgt_out <= step_val;
            if (step_val <= thr_code) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
      end
    end
  end

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && on_req) |=> (!busy && !done && $stable(tgt_out)));
  p_step_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && tgt_out != $past(tgt_out)) |->
      (($past(tgt_out) - tgt_out) <= CODE_W'(STEP_CODES) && tgt_out >= thr_code));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && off_req && !on_req) |=> (busy && tgt_out == $past(tgt_in)));
endmodule

// File: tb/soft_stop_seq_tb.sv
module soft_stop_seq_tb_top;
  logic clk = 0, rst_n = 0, tick_us = 0, off_req = 0, on_req = 0;
  logic [15:0] cfg_word = 0;
  logic [9:0] tgt_in = 0, thr_code = 0, tgt_out;
  logic busy, done;
  int n_tests = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  soft_stop_seq dut_i (.clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_word(cfg_word),
    .off_req(off_req), .on_req(on_req), .tgt_in(tgt_in), .thr_code(thr_code),
    .tgt_out(tgt_out), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_us <= ((cyc % 3) == 0);
  end

  // behavioural reference
  bit m_busy = 0, m_done = 0, m_ramp = 0;
  int m_tgt = 0, m_cnt = 0, m_dly = 1, m_fall = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_tgt <= 0; m_cnt <= 0; m_ramp <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (off_req && !on_req) begin
          m_busy <= 1; m_ramp <= 0; m_cnt <= 0; m_tgt <= int'(tgt_in);
          m_dly  <= (cfg_word[15:10] == 0) ? 1 : int'(cfg_word[15:10]) * 250;
          m_fall <= (cfg_word[9:0] == 0) ? 1 : int'(cfg_word[9:0]);
        end
      end else if (on_req) begin
        m_busy <= 0;
      end else if (tick_us) begin
        if (!m_ramp) begin
          if (m_cnt + 1 >= m_dly) begin m_ramp <= 1; m_cnt <= 0; end
          else m_cnt <= m_cnt + 1;
        end else if (m_cnt + 1 >= m_fall) begin
          int nv;
          m_cnt <= 0;
          if (m_tgt <= int'(thr_code)) nv = m_tgt;
          else if (m_tgt - 5 > int'(thr_code)) nv = m_tgt - 5;
          else nv = int'(thr_code);
          m_tgt <= nv;
          if (nv <= int'(thr_code)) begin m_done <= 1; m_busy <= 0; end
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("tgt_out", int'(tgt_out), m_tgt);
    chk("busy", int'(busy), int'(m_busy));
    chk("done", int'(done), int'(m_done));
  end

  task automatic clks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_off(logic [15:0] cfg, int tin);
    @(negedge clk); cfg_word = cfg; tgt_in = 10'(tin); off_req = 1;
    @(negedge clk); off_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && m_busy; i++) @(negedge clk);
  endtask

  initial begin
    clks(3);
    tag = "R1";
    chk("reset busy", int'(busy), 0); chk("reset done", int'(done), 0);
    chk("reset tgt", int'(tgt_out), 0);
    rst_n = 1; clks(2);

    tag = "R2 R3 R4 R6"; thr_code = 70;
    pulse_off({6'd1, 10'd3}, 100);
    chk("start busy", int'(busy), 1); chk("start tgt", int'(tgt_out), 100);
    wait_idle(); clks(2);
    tag = "R5"; chk("end at threshold", int'(tgt_out), 70);

    tag = "R9 R5"; thr_code = 20;
    pulse_off(16'd0, 33); wait_idle(); clks(2);
    chk("saturated", int'(tgt_out), 20);

    tag = "R7 delay"; thr_code = 0;
    pulse_off({6'd2, 10'd2}, 200); clks(100);
    @(negedge clk) on_req = 1; @(negedge clk) on_req = 0;
    chk("abort busy", int'(busy), 0); chk("abort tgt", int'(tgt_out), 200);

    tag = "R7 ramp";
    pulse_off({6'd0, 10'd1}, 300); clks(40);
    @(negedge clk) on_req = 1; @(negedge clk) on_req = 0;
    chk("abort busy", int'(busy), 0); clks(3);

    tag = "R8 R10"; thr_code = 40;
    pulse_off({6'd1, 10'd4}, 80); clks(50);
    cfg_word = 16'hFFFF; tgt_in = 10'd500;
    @(negedge clk) off_req = 1; @(negedge clk) off_req = 0;
    wait_idle(); clks(2);
    chk("final", int'(tgt_out), 40);

    tag = "R5 below"; thr_code = 50;
    pulse_off(16'd1, 10); wait_idle(); clks(2);
    chk("unchanged", int'(tgt_out), 10);

    tag = "R2 both"; @(negedge clk) begin off_req = 1; on_req = 1; end
    @(negedge clk) begin off_req = 0; on_req = 0; end
    chk("no start", int'(busy), 0);
    clks(5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule